// File: doc/BRIEF.md
# Fixed-Period Slot PWM with Released Disable

This block makes a pulse-width modulated output whose period is fixed at 1 ms and never changes. A prescaler divides the system clock so that a slot counter advances 256 times per period, and it wraps freely without stopping. An 8-bit duty code is compared against the slot counter. The compare result is gated by an enable bit and then drives the pin.

The pin is modelled as a data bit and an output-enable bit. Clearing the enable releases the pin to high impedance; it does not drive the pin low. The duty code sets a high time of (code+1)/256 of the period, so the narrowest pulse is one slot and a 0% duty cycle cannot be produced. Configuration goes through a small synchronous register port with an address, a write strobe, write data and registered read data. Writes take effect straight away, with no alignment to the period. A pulse may therefore be cut short or stretched in the period where the change lands.

Top module: `slot_pwm`

## Requirements
- R1: After synchronous reset, `pwm_o` and `pwm_oe` are 0, and both the control register (address 0xD2) and the duty register (address 0xD8) read back 0.
- R2: The slot counter advances once every DIV = CLK_HZ/256000 clocks. CLK_HZ must be a whole multiple of 256 kHz.
- R3: The slot counter runs from 0 to 255 and wraps to 0. One period is 256*DIV clocks, and register writes never restart or re-phase it.
- R4: While enabled, `pwm_o` is high exactly when the slot counter is less than or equal to the duty code, so each period has (duty+1)*DIV high clocks.
- R5: Duty code 255 holds `pwm_o` high for the whole period. Duty code 0 still gives one slot (DIV clocks) high per period, so 0% is never produced while enabled.
- R6: The enable is bit 7 of the control register at address 0xD2. When it is clear, `pwm_oe` is 0 and `pwm_o` is 0, so the pin is released rather than driven low.
- R7: The duty code is the whole 8-bit register at address 0xD8.
- R8: Bits 6..0 of the control register are stored and read back, but they have no effect on `pwm_o` or `pwm_oe`.
- R9: `cfg_rdata` shows the register selected by `cfg_addr` one clock later. Addresses with no register read as 0.
- R10: A register is updated on the clock edge where `cfg_wr` is sampled high. The outputs reflect the new value on the next edge, at whatever slot the counter is in, with no wait for a period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Register address for read and write |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data |
| pwm_o | output | 1 | Pin data value |
| pwm_oe | output | 1 | Pin output-enable (0 = released) |

## Verification
A configuration write can land in the same clock as a prescaler tick that moves the slot counter, including the tick that wraps it from 255 to 0. The compare then sees a new duty or enable and a new slot value together. The bench provokes this with writes at random clock offsets spread over many periods, plus directed writes timed next to slot boundaries. On every clock it compares both output bits against a cycle-level model built from the requirements. A high-time count over a full period then confirms that the steady-state pulse width returns to (duty+1)*DIV, and that the period was not re-phased by the write.

// File: rtl/slot_pwm_pkg.sv
package slot_pwm_pkg;
  localparam int SLOTS  = 256;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int DATA_W = 8;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic  enable;
    slot_t duty;
  } pwm_cfg_t;
endpackage

// File: rtl/slot_pwm_prescale.sv
module slot_pwm_prescale #(
  parameter int DIV   = 4,
  parameter int CNT_W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);
  generate
    if (DIV > 1) begin : g_div
      localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign tick = (cnt_q == LAST);
      assign cnt  = cnt_q;
    end else begin : g_pass
      assign tick = 1'b1;
      assign cnt  = '0;
    end
  endgenerate
endmodule

// File: rtl/slot_pwm_regs.sv
module slot_pwm_regs
  import slot_pwm_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD2,
  parameter logic [ADDR_W-1:0] DUTY_ADDR = 8'hD8,
  parameter int                EN_BIT    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output pwm_cfg_t          cfg
);
  logic [DATA_W-1:0] ctrl_q;
  slot_t             duty_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      duty_q <= '0;
    end else if (wr) begin
      if (addr == CTRL_ADDR) ctrl_q <= wdata;
      if (addr == DUTY_ADDR) duty_q <= wdata[SLOT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      unique case (addr)
        CTRL_ADDR: rdata_q <= ctrl_q;
        DUTY_ADDR: rdata_q <= DATA_W'(duty_q);
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign rdata      = rdata_q;
  assign cfg.enable = ctrl_q[EN_BIT];
  assign cfg.duty   = duty_q;
endmodule

// File: rtl/slot_pwm_core.sv
module slot_pwm_core
  import slot_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  pwm_cfg_t cfg,
  output slot_t    slot,
  output logic     pin_d,
  output logic     pin_oe
);
  slot_t slot_q;
  logic  d_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (tick) begin
      slot_q <= slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q  <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      d_q  <= cfg.enable && (slot_q <= cfg.duty);
      oe_q <= cfg.enable;
    end
  end

  assign slot   = slot_q;
  assign pin_d  = d_q;
  assign pin_oe = oe_q;
endmodule

// File: rtl/slot_pwm.sv
module slot_pwm
  import slot_pwm_pkg::*;
#(
  parameter int                CLK_HZ    = 256_000_000,
  parameter int                PERIOD_HZ = 1000,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD2,
  parameter logic [ADDR_W-1:0] DUTY_ADDR = 8'hD8,
  parameter int                EN_BIT    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              pwm_o,
  output logic              pwm_oe
);
  localparam int DIV   = CLK_HZ / (PERIOD_HZ * SLOTS);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic             tick;
  logic [CNT_W-1:0] pre_cnt;
  pwm_cfg_t         cfg;
  slot_t            slot;

  slot_pwm_prescale #(.DIV(DIV), .CNT_W(CNT_W)) i_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .cnt (pre_cnt)
  );

  slot_pwm_regs #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .DUTY_ADDR(DUTY_ADDR),
    .EN_BIT   (EN_BIT)
  ) i_regs (
    .clk  (clk),
    .rst  (rst),
    .addr (cfg_addr),
    .wr   (cfg_wr),
    .wdata(cfg_wdata),
    .rdata(cfg_rdata),
    .cfg  (cfg)
  );

  slot_pwm_core i_core (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .cfg   (cfg),
    .slot  (slot),
    .pin_d (pwm_o),
    .pin_oe(pwm_oe)
  );
endmodule

// File: rtl/slot_pwm_chk.sv
module slot_pwm_chk
  import slot_pwm_pkg::*;
#(
  parameter int                CLK_HZ    = 256_000_000,
  parameter int                PERIOD_HZ = 1000,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD2,
  parameter logic [ADDR_W-1:0] DUTY_ADDR = 8'hD8,
  parameter int                EN_BIT    = 7,
  parameter int                CNT_W     = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              cfg_wr,
  input logic [7:0]        cfg_wdata,
  input logic              pwm_o,
  input logic              pwm_oe,
  input logic              tick,
  input logic [CNT_W-1:0]  pre_cnt,
  input slot_t             slot,
  input pwm_cfg_t          cfg
);
  localparam int DIV = CLK_HZ / (PERIOD_HZ * SLOTS);

  // R2
  initial clk_ratio_chk : assert (CLK_HZ % (PERIOD_HZ * SLOTS) == 0 && DIV >= 1)
    else $error("clock frequency is not a multiple of the slot rate");

  // R2
  prescale_range_chk : assert property (@(posedge clk) disable iff (rst)
    int'(pre_cnt) < DIV);

  // R3
  slot_wrap_chk : assert property (@(posedge clk) disable iff (rst)
    (tick && slot == slot_t'(SLOTS - 1)) |=> slot == '0);

  // R3
  slot_hold_chk : assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(slot));

  // R4
  compare_chk : assert property (@(posedge clk) disable iff (rst)
    pwm_o |-> $past(slot <= cfg.duty));

  // R5
  full_high_chk : assert property (@(posedge clk) disable iff (rst)
    $past(cfg.enable && cfg.duty == slot_t'(SLOTS - 1)) |-> pwm_o);

  // R6
  released_low_chk : assert property (@(posedge clk) disable iff (rst)
    !pwm_oe |-> !pwm_o);

  // R6
  oe_follow_chk : assert property (@(posedge clk) disable iff (rst)
    pwm_oe == $past(cfg.enable));

  // R10
  enable_write_chk : assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == CTRL_ADDR) |=> cfg.enable == $past(cfg_wdata[EN_BIT]));

  // R7
  duty_write_chk : assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == DUTY_ADDR) |=> cfg.duty == $past(cfg_wdata[SLOT_W-1:0]));
endmodule

bind slot_pwm slot_pwm_chk #(
  .CLK_HZ   (CLK_HZ),
  .PERIOD_HZ(PERIOD_HZ),
  .ADDR_W   (ADDR_W),
  .CTRL_ADDR(CTRL_ADDR),
  .DUTY_ADDR(DUTY_ADDR),
  .EN_BIT   (EN_BIT),
  .CNT_W    (CNT_W)
) i_slot_pwm_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_addr (cfg_addr),
  .cfg_wr   (cfg_wr),
  .cfg_wdata(cfg_wdata),
  .pwm_o    (pwm_o),
  .pwm_oe   (pwm_oe),
  .tick     (tick),
  .pre_cnt  (pre_cnt),
  .slot     (slot),
  .cfg      (cfg)
);

// File: tb/test_slot_pwm.sv
`timescale 1ns/1ps
module test_slot_pwm;
  localparam int CLK_HZ = 1_024_000;
  localparam int DIV    = CLK_HZ / (1000 * 256);
  localparam int PER    = 256 * DIV;
  localparam logic [7:0] CTRL = 8'hD2;
  localparam logic [7:0] DUTY = 8'hD8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_addr = '0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       pwm_o, pwm_oe;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  live_chk = 1'b0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  slot_pwm #(.CLK_HZ(CLK_HZ)) i_slot_pwm (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
  );

  // Reference timing model built from R2, R3, R4, R6, R10
  int         m_pre = 0;
  int         m_slot = 0;
  logic [7:0] m_ctrl = '0;
  logic [7:0] m_duty = '0;
  logic       e_o = 1'b0, e_oe = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_pre <= 0; m_slot <= 0; m_ctrl <= '0; m_duty <= '0;
      e_o <= 1'b0; e_oe <= 1'b0;
    end else begin
      e_oe <= m_ctrl[7];
      e_o  <= m_ctrl[7] && (m_slot <= int'(m_duty));
      if (m_pre == DIV - 1) begin
        m_pre  <= 0;
        m_slot <= (m_slot + 1) % 256;
      end else begin
        m_pre <= m_pre + 1;
      end
      if (cfg_wr && cfg_addr == CTRL) m_ctrl <= cfg_wdata;
      if (cfg_wr && cfg_addr == DUTY) m_duty <= cfg_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live_chk) begin
      // R4 R6 R10: cycle-level output check
      check(pwm_oe == e_oe, "R6/R10 oe", int'(pwm_oe), int'(e_oe));
      check(pwm_o == e_o, "R4/R10 data", int'(pwm_o), int'(e_o));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    cfg_addr = a; cfg_wr = 1'b0;
    @(negedge clk);
    check(cfg_rdata == exp, req, int'(cfg_rdata), int'(exp));
  endtask

  task automatic measure(input int exp_high, input int exp_oe, input string req);
    int hi = 0;
    int oe = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      hi += int'(pwm_o);
      oe += int'(pwm_oe);
    end
    check(hi == exp_high, req, hi, exp_high);
    check(oe == exp_oe, req, oe, exp_oe);
  endtask

  function automatic int high_of(input logic [7:0] d);
    return (int'(d) + 1) * DIV;
  endfunction

  initial begin
    void'($urandom(32'h5107));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(pwm_o == 1'b0, "R1 pwm_o", int'(pwm_o), 0);
    check(pwm_oe == 1'b0, "R1 pwm_oe", int'(pwm_oe), 0);
    rd(CTRL, 8'h00, "R1 ctrl read");
    rd(DUTY, 8'h00, "R1 duty read");
    live_chk = 1'b1;

    // R6: disabled with a duty set, pin stays released
    wr(DUTY, 8'd100);
    measure(0, 0, "R6 released");

    // R7 R4: duty register sets the width
    wr(CTRL, 8'h80);
    measure(high_of(8'd100), PER, "R4 width 100");
    rd(DUTY, 8'd100, "R7 duty read");

    // R5: minimum one slot, never 0%
    wr(DUTY, 8'd0);
    measure(DIV, PER, "R5 min width");
    // R5: full period high
    wr(DUTY, 8'd255);
    measure(PER, PER, "R5 full width");

    // R8: other ctrl bits stored, no effect
    wr(DUTY, 8'd37);
    wr(CTRL, 8'hFF);
    measure(high_of(8'd37), PER, "R8 upper set");
    rd(CTRL, 8'hFF, "R8 readback");
    wr(CTRL, 8'h80);
    measure(high_of(8'd37), PER, "R8 upper clear");
    wr(CTRL, 8'h5A);
    measure(0, 0, "R8 R6 low bits only");
    rd(CTRL, 8'h5A, "R8 readback 5A");

    // R9: unmapped addresses read 0
    rd(8'hD3, 8'h00, "R9 unmapped D3");
    rd(8'h00, 8'h00, "R9 unmapped 00");

    // R2 R3: slot period seen as a rising-edge spacing with duty 0
    wr(CTRL, 8'h80);
    wr(DUTY, 8'd0);
    begin
      int t0, t1, cyc;
      logic prev;
      cyc = 0; t0 = -1; t1 = -1;
      prev = pwm_o;
      while (t1 < 0 && cyc < 3 * PER) begin
        @(negedge clk);
        cyc++;
        if (pwm_o && !prev) begin
          if (t0 < 0) t0 = cyc; else t1 = cyc;
        end
        prev = pwm_o;
      end
      check(t1 - t0 == PER, "R2 R3 period", t1 - t0, PER);
    end

    // R10 R3: writes near slot boundaries and the wrap, period not re-phased
    for (int k = 0; k < 40; k++) begin
      int w;
      w = int'($urandom_range(0, 2 * DIV));
      repeat (w) @(negedge clk);
      wr(DUTY, 8'($urandom_range(0, 255)));
    end

    // R10: constrained random mix of writes and reads, model compared every cycle
    for (int k = 0; k < 300; k++) begin
      int sel;
      logic [7:0] v;
      sel = int'($urandom_range(0, 9));
      v = 8'($urandom);
      repeat (int'($urandom_range(0, 30))) @(negedge clk);
      if (sel < 5) wr(DUTY, v);
      else if (sel < 8) wr(CTRL, v);
      else if (sel == 8) wr(8'($urandom_range(0, 200)), v);
      else rd(DUTY, m_duty, "R9 random read");
    end

    // steady-state width recheck after random traffic
    wr(CTRL, 8'h80);
    wr(DUTY, 8'd200);
    measure(high_of(8'd200), PER, "R4 width 200");

    live_chk = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule